// File: doc/BRIEF.md
# SDRAM Byte-Lane Data Path with Latency-Aligned Masking

This block sits between a memory controller's command sequencer and a 64-bit SDRAM data bus split into eight byte lanes. It owns only the data-side timing: on a write beat it turns the per-lane mask into byte write enables in the same cycle, and on a read beat it carries the word fetched from the array down a short pipeline so that it appears on the bus exactly the programmed CAS latency later. Address generation and the storage array are outside the block.

Each lane has one mask bit, and a mask acts differently on the two directions. On writes a mask bit sampled high suppresses that lane's enable at once. On reads the mask runs through its own two-stage delay, independent of the read-data delay, so a mask raised in the middle of a burst hides exactly one beat on the bus two cycles later. A lane whose output enable is low models high impedance and drives zeros on its data bits. The CAS latency (2 or 3) is held in a small setting register loaded by a strobe.

Top module: `sdram_lane_datapath`

## Requirements
- R1: On a write beat (`beat_vld`=1, `beat_wr`=1) in a cycle, `arr_wr_en[i]` is the inverse of `lane_mask[i]` in that same cycle, and `arr_wr_data` equals `wr_data` in that same cycle.
- R2: `arr_wr_en` is all zeros whenever `beat_vld`=0 or the beat is a read (`beat_wr`=0).
- R3: A read beat (`beat_vld`=1, `beat_wr`=0) sampled at rising edge k, with no mask hitting it, drives all eight lanes with the `arr_rd_data` word sampled at edge k during the single cycle that follows edge k+CL.
- R4: When `cfg_load` is sampled high, `cfg_cl3` selects the latency (0 gives CL=2, 1 gives CL=3) for read beats sampled at that edge and later; after reset the latency is 3.
- R5: A mask bit `lane_mask[i]` sampled high at edge j forces `bus_dq_oe[i]` low in the cycle after edge j+2, whether or not it was sampled on a read beat, so a single beat inside a burst can be hidden.
- R6: In any cycle in which no read beat is due, `bus_dq_oe` is all zeros.
- R7: Lane i covers data bits [8i+7:8i] and mask bit i; a lane with `bus_dq_oe[i]`=0 drives zeros on its bits of `bus_dq_out`.
- R8: Reset (active low, asynchronous) clears every pipeline stage, so outputs are idle during reset and a read beat in flight at reset never reaches the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the latency setting |
| cfg_cl3 | input | 1 | Latency choice: 0 = CL2, 1 = CL3 |
| beat_vld | input | 1 | A column beat is present this cycle |
| beat_wr | input | 1 | Beat direction: 1 = write, 0 = read |
| lane_mask | input | 8 | One mask bit per byte lane |
| wr_data | input | 64 | Write data from the controller |
| arr_rd_data | input | 64 | Word read from the array for a read beat |
| arr_wr_en | output | 8 | Per-lane write enables toward the array |
| arr_wr_data | output | 64 | Write data toward the array |
| bus_dq_out | output | 64 | Data driven onto the bus |
| bus_dq_oe | output | 8 | Per-lane output enable (0 = high impedance) |

## Verification
A write beat and the output of an earlier read can fall in the same cycle, and the mask sampled with that write both blocks its lanes at once and hides the same lanes on the read output two cycles later. The stimulus table places a write with a mask of 81h right after a run of reads, then reads around masked idle cycles, and every row states the expected enables, output lanes and the source row of the data. The bench judges each cycle at the ports, so a write mask leaking into the same cycle's read output, or a read mask applied with the wrong delay, shows up as a lane mismatch.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  localparam int SDL_LANES    = 8;
  localparam int SDL_LANE_W   = 8;
  localparam int SDL_MAX_CL   = 3;
  localparam int SDL_MIN_CL   = 2;
  localparam int SDL_MASK_LAT = 2;

  typedef enum logic {
    LAT_CL2 = 1'b0,
    LAT_CL3 = 1'b1
  } cas_lat_e;

endpackage

// File: rtl/sdl_wr_gate.sv
module sdl_wr_gate #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat_vld,
  input  logic                    beat_wr,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_en,
  output logic [LANES*LANE_W-1:0] wr_data_o
);

  logic wr_beat;

  always_comb begin
    wr_beat   = beat_vld & beat_wr;
    wr_en     = '0;
    wr_data_o = wr_data;
    if (wr_beat) begin
      wr_en = ~lane_mask;
    end
  end

  // R2
  no_wr_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_vld && beat_wr) |-> (wr_en == '0));

  // R1
  mask_blocks_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && beat_wr) |-> ((wr_en & lane_mask) == '0));

endmodule

// File: rtl/sdl_delay_line.sv
module sdl_delay_line #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2,
  localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  input  logic [SEL_W-1:0] tap_sel,
  output logic [WIDTH-1:0] tap_out
);

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;
  logic [DEPTH-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    if (en) begin
      stage_d[0] = din;
      for (int s = 1; s < DEPTH; s++) begin
        stage_d[s] = stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  always_comb begin
    tap_out = stage_q[tap_sel];
  end

endmodule

// File: rtl/sdl_lane_drive.sv
module sdl_lane_drive #(
  parameter int LANE_W = 8
) (
  input  logic              beat_due,
  input  logic              lane_hide,
  input  logic [LANE_W-1:0] lane_data,
  output logic              dq_oe,
  output logic [LANE_W-1:0] dq_out
);

  always_comb begin
    dq_oe  = beat_due & ~lane_hide;
    dq_out = dq_oe ? lane_data : '0;
  end

endmodule

// File: rtl/sdram_lane_datapath.sv
module sdram_lane_datapath
  import sdl_pkg::*;
#(
  parameter int LANES  = SDL_LANES,
  parameter int LANE_W = SDL_LANE_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_cl3,
  input  logic                    beat_vld,
  input  logic                    beat_wr,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [LANES*LANE_W-1:0] arr_rd_data,
  output logic [LANES-1:0]        arr_wr_en,
  output logic [LANES*LANE_W-1:0] arr_wr_data,
  output logic [LANES*LANE_W-1:0] bus_dq_out,
  output logic [LANES-1:0]        bus_dq_oe
);

  localparam int DATA_W   = LANES * LANE_W;
  localparam int RD_DEPTH = SDL_MAX_CL;
  localparam int RD_SEL_W = (RD_DEPTH > 1) ? $clog2(RD_DEPTH) : 1;
  localparam int MK_DEPTH = SDL_MASK_LAT;
  localparam int MK_SEL_W = (MK_DEPTH > 1) ? $clog2(MK_DEPTH) : 1;

  // latency setting register
  cas_lat_e cl_q;
  cas_lat_e cl_d;

  always_comb begin
    cl_d = cl_q;
    if (cfg_load) begin
      cl_d = cfg_cl3 ? LAT_CL3 : LAT_CL2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_q <= LAT_CL3;
    end else begin
      cl_q <= cl_d;
    end
  end

  // write side: zero-latency byte gating
  sdl_wr_gate #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_wr_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_vld  (beat_vld),
    .beat_wr   (beat_wr),
    .lane_mask (lane_mask),
    .wr_data   (wr_data),
    .wr_en     (arr_wr_en),
    .wr_data_o (arr_wr_data)
  );

  // read side: data pipeline tapped by latency
  logic                rd_cmd;
  logic [RD_SEL_W-1:0] rd_tap_sel;
  logic [DATA_W:0]     rd_tap;
  logic                beat_due;
  logic [DATA_W-1:0]   beat_data;

  always_comb begin
    rd_cmd     = beat_vld & ~beat_wr;
    rd_tap_sel = (cl_q == LAT_CL3) ? RD_SEL_W'(SDL_MAX_CL - 1)
                                   : RD_SEL_W'(SDL_MIN_CL - 1);
    beat_due   = rd_tap[DATA_W];
    beat_data  = rd_tap[DATA_W-1:0];
  end

  sdl_delay_line #(
    .WIDTH (DATA_W + 1),
    .DEPTH (RD_DEPTH)
  ) u_rd_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (1'b1),
    .din     ({rd_cmd, arr_rd_data}),
    .tap_sel (rd_tap_sel),
    .tap_out (rd_tap)
  );

  // read side: independent mask pipeline
  logic [LANES-1:0] lane_hide;

  sdl_delay_line #(
    .WIDTH (LANES),
    .DEPTH (MK_DEPTH)
  ) u_mask_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (1'b1),
    .din     (lane_mask),
    .tap_sel (MK_SEL_W'(SDL_MASK_LAT - 1)),
    .tap_out (lane_hide)
  );

  // per-lane output drivers
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sdl_lane_drive #(
      .LANE_W (LANE_W)
    ) u_lane (
      .beat_due  (beat_due),
      .lane_hide (lane_hide[g]),
      .lane_data (beat_data[g*LANE_W +: LANE_W]),
      .dq_oe     (bus_dq_oe[g]),
      .dq_out    (bus_dq_out[g*LANE_W +: LANE_W])
    );
  end

  // cycles since reset, saturating, used to bound look-back in checks
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= 2'd0;
    end else if (age_q != 2'd3) begin
      age_q <= age_q + 2'd1;
    end
  end

  // R5
  mask_hides_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> ((bus_dq_oe & $past(lane_mask, 2)) == '0));

  // R6
  idle_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && !$past(rd_cmd, 2) && !$past(rd_cmd, 3)) |-> (bus_dq_oe == '0));

  // R3
  cl2_beat_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cl_q == LAT_CL2 && $past(rd_cmd, 2) && $past(lane_mask, 2) == '0)
      |-> (bus_dq_oe == '1));

  // R4
  cl3_beat_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && cl_q == LAT_CL3 && $past(rd_cmd, 3) && $past(lane_mask, 2) == '0)
      |-> (bus_dq_oe == '1));

endmodule

// File: tb/sdram_lane_datapath_tb.sv
module sdram_lane_datapath_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NROWS      = 13;

  typedef struct packed {
    logic       vld;
    logic       wr;
    logic [7:0] mask;
    logic [7:0] exp_oe;
    logic [3:0] exp_src;
  } vec_t;

  // CL3 (reset default). exp_src = row whose read word is expected on the bus.
  localparam vec_t VEC [NROWS] = '{
    '{1'b0, 1'b0, 8'h00, 8'h00, 4'hF},  // 0 idle
    '{1'b1, 1'b0, 8'h00, 8'h00, 4'hF},  // 1 read
    '{1'b1, 1'b0, 8'h00, 8'h00, 4'hF},  // 2 read
    '{1'b1, 1'b0, 8'h0F, 8'h00, 4'hF},  // 3 read, mask for row5 output
    '{1'b1, 1'b1, 8'h81, 8'hFF, 4'h1},  // 4 write + read@1 out
    '{1'b1, 1'b0, 8'h00, 8'hF0, 4'h2},  // 5 read, read@2 partly hidden
    '{1'b0, 1'b0, 8'h3C, 8'h7E, 4'h3},  // 6 idle, write mask hides read@3
    '{1'b0, 1'b0, 8'h00, 8'h00, 4'hF},  // 7 idle, nothing due
    '{1'b1, 1'b0, 8'hFF, 8'hC3, 4'h5},  // 8 read, read@5 hidden by idle mask
    '{1'b1, 1'b1, 8'h00, 8'h00, 4'hF},  // 9 write
    '{1'b0, 1'b0, 8'h00, 8'h00, 4'hF},  // 10 idle, mask FF lands on empty slot
    '{1'b0, 1'b0, 8'h00, 8'hFF, 4'h8},  // 11 read@8 out
    '{1'b0, 1'b0, 8'h00, 8'h00, 4'hF}   // 12 idle
  };

  logic        clk;
  logic        rst_n;
  logic        cfg_load;
  logic        cfg_cl3;
  logic        beat_vld;
  logic        beat_wr;
  logic [7:0]  lane_mask;
  logic [63:0] wr_data;
  logic [63:0] arr_rd_data;
  logic [7:0]  arr_wr_en;
  logic [63:0] arr_wr_data;
  logic [63:0] bus_dq_out;
  logic [7:0]  bus_dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sdram_lane_datapath u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .cfg_cl3     (cfg_cl3),
    .beat_vld    (beat_vld),
    .beat_wr     (beat_wr),
    .lane_mask   (lane_mask),
    .wr_data     (wr_data),
    .arr_rd_data (arr_rd_data),
    .arr_wr_en   (arr_wr_en),
    .arr_wr_data (arr_wr_data),
    .bus_dq_out  (bus_dq_out),
    .bus_dq_oe   (bus_dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rd_pat(input int r);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = 8'(r * 16 + i);
    return v;
  endfunction

  function automatic logic [63:0] exp_bus(input logic [7:0] oe, input int src);
    logic [63:0] v;
    v = rd_pat(src);
    for (int i = 0; i < 8; i++) if (!oe[i]) v[i*8 +: 8] = 8'h00;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [7:0] m, input int r);
    @(negedge clk);
    beat_vld    = v;
    beat_wr     = w;
    lane_mask   = m;
    arr_rd_data = rd_pat(r);
    wr_data     = ~rd_pat(r);
    cfg_load    = 1'b0;
    #2;
  endtask

  task automatic load_cl(input logic cl3);
    @(negedge clk);
    beat_vld  = 1'b0;
    beat_wr   = 1'b0;
    lane_mask = 8'h00;
    cfg_load  = 1'b1;
    cfg_cl3   = cl3;
    #2;
  endtask

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_cl3 = 1'b0;
    beat_vld = 1'b0; beat_wr = 1'b0; lane_mask = 8'h00;
    wr_data = '0; arr_rd_data = '0;
    repeat (3) @(negedge clk);
    #2;
    // R8: idle outputs under reset
    check("R8 reset oe", 64'(bus_dq_oe), 64'h0);
    check("R8 reset dq", bus_dq_out, 64'h0);
    check("R8 reset wr_en", 64'(arr_wr_en), 64'h0);
    rst_n = 1'b1;

    // table walk (CL3)
    for (int r = 0; r < NROWS; r++) begin
      logic [7:0] exp_wr;
      drive(VEC[r].vld, VEC[r].wr, VEC[r].mask, r);
      exp_wr = (VEC[r].vld && VEC[r].wr) ? ~VEC[r].mask : 8'h00;
      check($sformatf("R1/R2 row%0d wr_en", r), 64'(arr_wr_en), 64'(exp_wr));
      check($sformatf("R3/R5/R6 row%0d oe", r), 64'(bus_dq_oe), 64'(VEC[r].exp_oe));
      check($sformatf("R7 row%0d dq", r), bus_dq_out,
            exp_bus(VEC[r].exp_oe, int'(VEC[r].exp_src)));
      if (VEC[r].vld && VEC[r].wr)
        check($sformatf("R1 row%0d wr_data", r), arr_wr_data, ~rd_pat(r));
    end

    // R2: write flag without a valid beat
    drive(1'b0, 1'b1, 8'h00, 0);
    check("R2 no beat wr_en", 64'(arr_wr_en), 64'h0);

    // R4: CL2
    load_cl(1'b0);
    drive(1'b1, 1'b0, 8'h00, 13);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 cl2 +1 oe", 64'(bus_dq_oe), 64'h0);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 cl2 +2 oe", 64'(bus_dq_oe), 64'hFF);
    check("R4 cl2 +2 dq", bus_dq_out, rd_pat(13));
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R6 cl2 +3 oe", 64'(bus_dq_oe), 64'h0);

    // R4: back to CL3
    load_cl(1'b1);
    drive(1'b1, 1'b0, 8'h00, 14);
    drive(1'b0, 1'b0, 8'h00, 0);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 cl3 +2 oe", 64'(bus_dq_oe), 64'h0);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 cl3 +3 dq", bus_dq_out, rd_pat(14));

    // R8: reset with a read in flight, and CL returns to 3
    load_cl(1'b0);
    drive(1'b1, 1'b0, 8'h00, 15);
    @(negedge clk);
    beat_vld = 1'b0;
    rst_n = 1'b0;
    #2;
    check("R8 flight oe under reset", 64'(bus_dq_oe), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R8 flight discarded", 64'(bus_dq_oe), 64'h0);
    drive(1'b1, 1'b0, 8'h00, 12);
    drive(1'b0, 1'b0, 8'h00, 0);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 reset default +2", 64'(bus_dq_oe), 64'h0);
    drive(1'b0, 1'b0, 8'h00, 0);
    check("R4 reset default +3", bus_dq_out, rd_pat(12));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule